// File: doc/BRIEF.md
# Barrel Round-Robin Context Sequencer

This block lets one shared execution unit serve ten small processor contexts in turn. Each context owns a 12-bit accumulator, a 12-bit program counter, a supervisor/user mode bit and a halted flag. All of this state lives in a ten-stage ring that turns by one position on every clock. The stage at the front is presented to the execution unit as the current issue slot. The unit returns its result a fixed number of cycles later (parameter `EXU_LAT`). The ring writes that result into whichever stage the issuing context has reached by then, so results are never steered by arbitration.

A requester can swap a complete register block into one chosen context. The swap is acknowledged on the single cycle in which that context is next in line to issue. In the same edge the ring loads the new accumulator and program counter, flips the mode bit and clears the halt. The displaced values appear on the acknowledge cycle so that the requester can save them. No input ever changes the order of rotation: every context, halted or running, takes its slot once every ten cycles.

Top module: `barrel_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, context 0 is at the head. Every context then holds accumulator 0 and program counter 0, is in user mode (`issue_super`=0) and is running (`issue_run`=1).
- R2: `issue_ctx` steps by one every cycle in the order 0,1,…,9,0. Halts, write-backs and exchanges never change this order.
- R3: The head output shows the mode bit that the presented context holds (0 = user, 1 = supervisor).
- R4: A write-back driven with `wb_valid`=1 in cycle t+`EXU_LAT` updates the accumulator and program counter of the context issued in cycle t. The new values are seen at that context's next issue.
- R5: A write-back changes no context other than the one it belongs to.
- R6: A write-back with `wb_halt`=1 marks its context halted, so `issue_run`=0 at its later issues. The halted context keeps its slot in the rotation.
- R7: A write-back that arrives for a slot that was issued while its context was halted is ignored.
- R8: `xchg_ack` is high only while `xchg_req`=1 and `xchg_ctx` equals the context one step after `issue_ctx`. In that cycle `xchg_old_acc`, `xchg_old_pc` and `xchg_old_super` show the target's current state.
- R9: After an acknowledged exchange, the next issue is the target context. It shows `xchg_acc` and `xchg_pc`, its mode bit is inverted and it is running.
- R10: An exchange request naming a context number of 10 or more is never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_ctx | output | 4 | Number of the context at the head |
| issue_acc | output | 12 | Accumulator of the head context |
| issue_pc | output | 12 | Program counter of the head context |
| issue_super | output | 1 | Mode of the head context, 1 = supervisor |
| issue_run | output | 1 | Head context is not halted |
| wb_valid | input | 1 | Result returned for the slot issued `EXU_LAT` cycles ago |
| wb_acc | input | 12 | Result accumulator |
| wb_pc | input | 12 | Result program counter |
| wb_halt | input | 1 | Result halts the context |
| xchg_req | input | 1 | Exchange request, held until acknowledged |
| xchg_ctx | input | 4 | Target context of the exchange |
| xchg_acc | input | 12 | Accumulator to load |
| xchg_pc | input | 12 | Program counter to load |
| xchg_ack | output | 1 | Exchange takes effect at the coming edge |
| xchg_old_acc | output | 12 | Displaced accumulator of the target |
| xchg_old_pc | output | 12 | Displaced program counter of the target |
| xchg_old_super | output | 1 | Displaced mode bit of the target |

## Verification
The hardest case to reach is an exchange that is acknowledged while write-backs for other contexts are still in flight. Another hard case is a halted context that receives a stray write-back and is later brought back to life by an exchange. The bench runs a model of the execution unit that returns results for every running slot. Results can be limited to chosen contexts, and the model can also force bogus results into halted slots. Exchange requests are raised at an arbitrary point in the rotation and held until the ring brings the target next in line, so the acknowledge cycle and the pending results overlap on their own.

// File: rtl/barrel_pkg.sv
`timescale 1ns/1ps
package barrel_pkg;
  localparam int CTX_N  = 10;
  localparam int WORD_W = 12;
  localparam int ID_W   = $clog2(CTX_N);

  typedef logic [ID_W-1:0]   ctx_id_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    ctx_id_t id;
    word_t   acc;
    word_t   pc;
    logic    sup;
    logic    halted;
  } ctx_t;

  // successor in the rotation
  function automatic ctx_id_t id_after(ctx_id_t c);
    return (c == ctx_id_t'(CTX_N - 1)) ? '0 : ctx_id_t'(c + 1'b1);
  endfunction

  // ring stage that receives a result returning lat cycles after issue
  function automatic int wb_stage(int lat);
    return CTX_N - lat - 1;
  endfunction

  function automatic ctx_t ctx_reset(int idx);
    ctx_t c;
    c    = '0;
    c.id = ctx_id_t'(idx);
    return c;
  endfunction

  function automatic ctx_t apply_wb(ctx_t s, word_t a, word_t p, logic h);
    ctx_t r;
    r        = s;
    r.acc    = a;
    r.pc     = p;
    r.halted = h;
    return r;
  endfunction

  function automatic ctx_t apply_xchg(ctx_t s, word_t a, word_t p);
    ctx_t r;
    r        = s;
    r.acc    = a;
    r.pc     = p;
    r.sup    = ~s.sup;
    r.halted = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/issue_tag_pipe.sv
`timescale 1ns/1ps
module issue_tag_pipe
  import barrel_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  ctx_id_t in_id,
  input  logic    in_run,
  output ctx_id_t out_id,
  output logic    out_run
);
  ctx_id_t id_q  [LAT];
  logic    run_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        id_q[i]  <= '0;
        run_q[i] <= 1'b0;
      end
    end else begin
      id_q[0]  <= in_id;
      run_q[0] <= in_run;
      for (int i = 1; i < LAT; i++) begin
        id_q[i]  <= id_q[i-1];
        run_q[i] <= run_q[i-1];
      end
    end
  end

  assign out_id  = id_q[LAT-1];
  assign out_run = run_q[LAT-1];
endmodule

// File: rtl/barrel_ring.sv
`timescale 1ns/1ps
module barrel_ring
  import barrel_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wb_en,
  input  word_t   wb_acc,
  input  word_t   wb_pc,
  input  logic    wb_halt,
  input  logic    xg_en,
  input  word_t   xg_acc,
  input  word_t   xg_pc,
  output ctx_t    head,
  output ctx_t    on_deck,
  output ctx_id_t wb_slot_id
);
  localparam int WBP  = wb_stage(LAT);
  localparam int WSRC = WBP + 1;

  ctx_t ring     [CTX_N];
  ctx_t ring_nxt [CTX_N];

  always_comb begin
    for (int i = 0; i < CTX_N; i++) begin
      ring_nxt[i] = ring[(i + 1) % CTX_N];
    end
    if (wb_en) begin
      ring_nxt[WBP] = apply_wb(ring[WSRC], wb_acc, wb_pc, wb_halt);
    end
    if (xg_en) begin
      ring_nxt[0] = apply_xchg(ring[1], xg_acc, xg_pc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CTX_N; i++) ring[i] <= ctx_reset(i);
    end else begin
      for (int i = 0; i < CTX_N; i++) ring[i] <= ring_nxt[i];
    end
  end

  assign head       = ring[0];
  assign on_deck    = ring[1];
  assign wb_slot_id = ring[WSRC].id;

  // a halted head that is not refreshed by a result keeps its flag a full turn
  AST_HALT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (head.halted && !(wb_en && WBP == CTX_N - 1)) |=> ring[CTX_N-1].halted); // R6
endmodule

// File: rtl/xchg_gate.sv
`timescale 1ns/1ps
module xchg_gate
  import barrel_pkg::*;
(
  input  logic    req,
  input  ctx_id_t target,
  input  ctx_id_t on_deck_id,
  output logic    ack
);
  assign ack = req && (target == on_deck_id);
endmodule

// File: rtl/barrel_seq.sv
`timescale 1ns/1ps
module barrel_seq
  import barrel_pkg::*;
#(
  parameter int EXU_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ID_W-1:0]   issue_ctx,
  output logic [WORD_W-1:0] issue_acc,
  output logic [WORD_W-1:0] issue_pc,
  output logic              issue_super,
  output logic              issue_run,
  input  logic              wb_valid,
  input  logic [WORD_W-1:0] wb_acc,
  input  logic [WORD_W-1:0] wb_pc,
  input  logic              wb_halt,
  input  logic              xchg_req,
  input  logic [ID_W-1:0]   xchg_ctx,
  input  logic [WORD_W-1:0] xchg_acc,
  input  logic [WORD_W-1:0] xchg_pc,
  output logic              xchg_ack,
  output logic [WORD_W-1:0] xchg_old_acc,
  output logic [WORD_W-1:0] xchg_old_pc,
  output logic              xchg_old_super
);
  ctx_t    head;
  ctx_t    on_deck;
  ctx_id_t wb_slot_id;
  ctx_id_t tag_id;
  logic    tag_run;
  logic    wb_en;

  assign wb_en = wb_valid && tag_run;

  barrel_ring #(.LAT(EXU_LAT)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .wb_en      (wb_en),
    .wb_acc     (wb_acc),
    .wb_pc      (wb_pc),
    .wb_halt    (wb_halt),
    .xg_en      (xchg_ack),
    .xg_acc     (xchg_acc),
    .xg_pc      (xchg_pc),
    .head       (head),
    .on_deck    (on_deck),
    .wb_slot_id (wb_slot_id)
  );

  issue_tag_pipe #(.LAT(EXU_LAT)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_id   (head.id),
    .in_run  (~head.halted),
    .out_id  (tag_id),
    .out_run (tag_run)
  );

  xchg_gate u_xchg (
    .req        (xchg_req),
    .target     (xchg_ctx),
    .on_deck_id (on_deck.id),
    .ack        (xchg_ack)
  );

  assign issue_ctx      = head.id;
  assign issue_acc      = head.acc;
  assign issue_pc       = head.pc;
  assign issue_super    = head.sup;
  assign issue_run      = ~head.halted;
  assign xchg_old_acc   = on_deck.acc;
  assign xchg_old_pc    = on_deck.pc;
  assign xchg_old_super = on_deck.sup;

  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> issue_ctx == id_after($past(issue_ctx))); // R2
  AST_WB_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_slot_id == tag_id); // R4
  AST_ACK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_ack |-> ({1'b0, xchg_ctx} < (ID_W+1)'(CTX_N)) && id_after(issue_ctx) == xchg_ctx); // R8
  AST_XCHG_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_ack |=> issue_ctx == $past(xchg_ctx) && issue_acc == $past(xchg_acc)
      && issue_pc == $past(xchg_pc) && issue_super != $past(xchg_old_super)); // R9
  AST_XCHG_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_ack |=> issue_run); // R9
endmodule

// File: tb/test_barrel_seq.sv
`timescale 1ns/1ps
module test_barrel_seq;
  localparam int LAT = 3;
  localparam int N   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  issue_ctx;
  logic [11:0] issue_acc, issue_pc;
  logic        issue_super, issue_run;
  logic        wb_valid = 1'b0;
  logic [11:0] wb_acc = '0, wb_pc = '0;
  logic        wb_halt = 1'b0;
  logic        xchg_req = 1'b0;
  logic [3:0]  xchg_ctx = '0;
  logic [11:0] xchg_acc = '0, xchg_pc = '0;
  logic        xchg_ack;
  logic [11:0] xchg_old_acc, xchg_old_pc;
  logic        xchg_old_super;

  always #2.5 clk = ~clk;

  barrel_seq #(.EXU_LAT(LAT)) i_barrel_seq (
    .clk(clk), .rst_n(rst_n),
    .issue_ctx(issue_ctx), .issue_acc(issue_acc), .issue_pc(issue_pc),
    .issue_super(issue_super), .issue_run(issue_run),
    .wb_valid(wb_valid), .wb_acc(wb_acc), .wb_pc(wb_pc), .wb_halt(wb_halt),
    .xchg_req(xchg_req), .xchg_ctx(xchg_ctx), .xchg_acc(xchg_acc), .xchg_pc(xchg_pc),
    .xchg_ack(xchg_ack), .xchg_old_acc(xchg_old_acc), .xchg_old_pc(xchg_old_pc),
    .xchg_old_super(xchg_old_super)
  );

  int n_chk = 0, n_err = 0;
  int m_acc [N], m_pc [N];
  bit m_sup [N], m_halt [N];
  bit exe_mask [N], halt_req [N];
  bit force_wb = 0;
  bit xg_on = 0, xg_done = 0;
  int xg_tgt = 0, xg_a = 0, xg_p = 0;
  int exp_head = 0, cyc = 0;
  int h_id [16], h_acc [16], h_pc [16];
  bit h_run [16], h_exe [16], h_halt [16];

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  // one issue slot: check head against the model, play execution unit and requester
  task automatic tick();
    int  slot, old, wa, wp;
    bit  wb_do, ack_exp;
    string xreq;
    old = 0; wa = 0; wp = 0;
    chk(int'(issue_ctx) == exp_head, "R2", int'(issue_ctx), exp_head);
    chk(int'(issue_acc) == m_acc[exp_head], "R4", int'(issue_acc), m_acc[exp_head]);
    chk(int'(issue_pc) == m_pc[exp_head], "R4", int'(issue_pc), m_pc[exp_head]);
    chk(issue_super == m_sup[exp_head], "R3", int'(issue_super), int'(m_sup[exp_head]));
    chk(issue_run == !m_halt[exp_head], "R6", int'(issue_run), int'(!m_halt[exp_head]));
    slot = cyc % 16;
    h_id[slot]   = exp_head;
    h_run[slot]  = !m_halt[exp_head];
    h_exe[slot]  = (exe_mask[exp_head] && !m_halt[exp_head]) || force_wb;
    h_acc[slot]  = m_acc[exp_head];
    h_pc[slot]   = m_pc[exp_head];
    h_halt[slot] = halt_req[exp_head];
    wb_do = 0;
    if (cyc >= LAT) begin
      old   = (cyc - LAT) % 16;
      wb_do = h_exe[old];
    end
    if (wb_do && h_run[old]) begin
      wa = (h_acc[old] + h_id[old] + 1) & 'hFFF;
      wp = (h_pc[old] + 1) & 'hFFF;
      wb_halt = h_halt[old];
    end else begin
      wa = 'hABC; wp = 'h5A5; wb_halt = 1'b0;
    end
    wb_valid = wb_do;
    wb_acc   = 12'(wa);
    wb_pc    = 12'(wp);
    xchg_req = xg_on;
    xchg_ctx = 4'(xg_tgt);
    xchg_acc = 12'(xg_a);
    xchg_pc  = 12'(xg_p);
    #1;
    ack_exp = xg_on && xg_tgt < N && ((exp_head + 1) % N == xg_tgt);
    xreq = (xg_tgt >= N) ? "R10" : "R8";
    chk(xchg_ack == ack_exp, xreq, int'(xchg_ack), int'(ack_exp));
    if (ack_exp) begin
      chk(int'(xchg_old_acc) == m_acc[xg_tgt], "R8", int'(xchg_old_acc), m_acc[xg_tgt]);
      chk(int'(xchg_old_pc) == m_pc[xg_tgt], "R8", int'(xchg_old_pc), m_pc[xg_tgt]);
      chk(xchg_old_super == m_sup[xg_tgt], "R8", int'(xchg_old_super), int'(m_sup[xg_tgt]));
    end
    @(posedge clk);
    if (wb_do && h_run[old]) begin
      m_acc[h_id[old]]  = wa;
      m_pc[h_id[old]]   = wp;
      m_halt[h_id[old]] = h_halt[old];
    end
    if (ack_exp) begin
      m_acc[xg_tgt]  = xg_a;
      m_pc[xg_tgt]   = xg_p;
      m_sup[xg_tgt]  = !m_sup[xg_tgt];
      m_halt[xg_tgt] = 1'b0;
      xg_on   = 0;
      xg_done = 1;
    end
    exp_head = (exp_head + 1) % N;
    cyc++;
    @(negedge clk);
  endtask

  task automatic go_to(int c);
    while (exp_head != c) tick();
  endtask

  task automatic t_reset();
    for (int i = 0; i < N; i++) begin
      chk(int'(issue_acc) == 0 && int'(issue_pc) == 0, "R1", int'(issue_pc), 0);
      chk(issue_super == 1'b0 && issue_run == 1'b1, "R1", int'(issue_super), 0);
      tick();
    end
    chk(int'(issue_ctx) == 0, "R2", int'(issue_ctx), 0);
  endtask

  task automatic t_only_one();
    int a4, p4, a5;
    for (int i = 0; i < N; i++) exe_mask[i] = (i == 5);
    go_to(4); a4 = int'(issue_acc); p4 = int'(issue_pc);
    tick(); a5 = int'(issue_acc);
    repeat (25) tick();
    go_to(4);
    chk(int'(issue_acc) == a4 && int'(issue_pc) == p4, "R5", int'(issue_acc), a4);
    tick();
    chk(int'(issue_acc) != a5, "R4", int'(issue_acc), a5 + 6);
  endtask

  task automatic t_all_run();
    for (int i = 0; i < N; i++) exe_mask[i] = 1;
    repeat (40) tick();
  endtask

  task automatic t_halt();
    int s_acc;
    halt_req[3] = 1;
    repeat (20) tick();
    halt_req[3] = 0;
    go_to(3);
    chk(issue_run == 1'b0, "R6", int'(issue_run), 0);
    s_acc = int'(issue_acc);
    force_wb = 1;
    repeat (30) tick();
    force_wb = 0;
    go_to(3);
    chk(int'(issue_acc) == s_acc, "R7", int'(issue_acc), s_acc);
    chk(issue_run == 1'b0, "R6", int'(issue_run), 0);
  endtask

  task automatic t_xchg(int tgt, int a, int p, bit sup_exp);
    xg_done = 0; xg_on = 1; xg_tgt = tgt; xg_a = a; xg_p = p;
    for (int k = 0; k < 12 && !xg_done; k++) tick();
    chk(xg_done, "R8", int'(xg_done), 1);
    chk(int'(issue_ctx) == tgt, "R9", int'(issue_ctx), tgt);
    chk(int'(issue_acc) == a && int'(issue_pc) == p, "R9", int'(issue_acc), a);
    chk(issue_super == sup_exp, "R9", int'(issue_super), int'(sup_exp));
    chk(issue_run == 1'b1, "R9", int'(issue_run), 1);
    xchg_req = 1'b0;
    repeat (7) tick();
  endtask

  task automatic t_bad_target();
    xg_done = 0; xg_on = 1; xg_tgt = 12; xg_a = 1; xg_p = 1;
    repeat (25) tick();
    chk(!xg_done, "R10", int'(xg_done), 0);
    xg_on = 0; xchg_req = 1'b0;
    tick();
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_acc[i] = 0; m_pc[i] = 0; m_sup[i] = 0; m_halt[i] = 0;
      exe_mask[i] = 0; halt_req[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_only_one();
    t_all_run();
    t_halt();
    t_xchg(3, 'h123, 'h456, 1'b1);
    t_xchg(3, 'h0FE, 'h010, 1'b0);
    t_xchg(0, 'hFFF, 'h800, 1'b1);
    t_bad_target();
    t_all_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #100000;
    n_err++;
    $display("FAIL R2 watchdog actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule